// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A half-period length is selected from one of two divisor inputs. In linear mode the serial clock runs at the module clock divided by 2(N+1). In power-of-two mode it runs at the module clock divided by 2^(M+1). Both modes give a 50% duty cycle. The fastest setting (linear, N = 0) toggles the serial clock on every module clock edge, which gives half the module clock rate.

The transfer engine holds `run_i` high for the length of a burst. While `run_i` is low the serial clock rests at the idle polarity, and the divisor inputs are captured on every cycle. Once a burst starts, the captured half-period is frozen, so a divisor change cannot shorten or stretch a period already in progress. Alongside each serial clock transition the block emits a one-cycle strobe in the module clock domain. The leading strobe marks the edge that leaves the idle level and the trailing strobe marks the return to it. The shifter uses these strobes to sample and launch data.

Top module: `spi_sclk_div`

## Requirements
- R1: With `lin_mode_i` = 1, each half-period of `sclk_o` lasts `lin_div_i` + 1 module clock cycles (N = 0 gives 1 cycle, N = 255 gives 256).
- R2: With `lin_mode_i` = 0, each half-period of `sclk_o` lasts 2^`exp_div_i` module clock cycles, so `exp_div_i` = 15 gives a full period of 65536 cycles.
- R3: `lin_mode_i` = 1 selects the linear divisor and `lin_mode_i` = 0 selects the power-of-two divisor; the unselected field has no effect.
- R4: While `run_i` is low (and on the cycle after it falls), `sclk_o` equals `cpol_i` and both strobes are low.
- R5: After the first rising clock edge at which `run_i` is sampled high, the first `sclk_o` transition occurs H edges later (H is the half-period), and every later transition follows H edges after the previous one.
- R6: `lead_o` is high for exactly the cycle in which `sclk_o` has just left the `cpol_i` level, and `trail_o` for exactly the cycle in which it has just returned to it. The two strobes are never high together and neither stays high for two cycles.
- R7: Divisor inputs (`lin_div_i`, `exp_div_i`, `lin_mode_i`) are captured only while idle; changes while `run_i` is high do not alter the running period. The new value applies from the next burst.
- R8: When `run_i` falls, `sclk_o` returns to `cpol_i` on the next cycle without emitting a strobe. A burst started again uses the half-period captured while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_div_i | input | 8 | Linear divisor N |
| exp_div_i | input | 4 | Power-of-two divisor M |
| lin_mode_i | input | 1 | 1 selects linear, 0 selects power-of-two |
| run_i | input | 1 | Burst active, from the transfer engine |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe: serial clock just left idle level |
| trail_o | output | 1 | Strobe: serial clock just returned to idle level |

## Verification
At the fastest setting, a trailing strobe and the next leading strobe fall in consecutive cycles. A divisor write can also land in the same cycle as a terminal count that would otherwise reload the half-period. The bench runs N = 0 to confirm that the strobes alternate every cycle and never overlap. It also rewrites both divisor fields and the mode bit on the very cycle a leading strobe appears, then confirms that the following trailing and leading strobes still keep the old half-period and that only a restarted burst picks up the new one.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;

  // counter width wide enough for both the linear field and 2^(2^EXP_W - 1)
  function automatic int unsigned cnt_width(int unsigned lin_w, int unsigned exp_w);
    int unsigned pw;
    pw = 1 << exp_w;
    return (pw > lin_w) ? pw : lin_w;
  endfunction

endpackage

// File: rtl/sclk_div_cfg.sv
module sclk_div_cfg
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LIN_W-1:0] lin_div_i,
  input  logic [EXP_W-1:0] exp_div_i,
  input  logic             lin_mode_i,
  output logic [CNT_W-1:0] term_o
);

  div_mode_e        mode_w;
  logic [CNT_W-1:0] lin_term_w;
  logic [CNT_W-1:0] pow_term_w;
  logic [CNT_W-1:0] next_term_w;
  logic [CNT_W-1:0] term_q;

  assign mode_w     = div_mode_e'(lin_mode_i);
  assign lin_term_w = CNT_W'(lin_div_i);
  assign pow_term_w = (CNT_W'(1) << exp_div_i) - CNT_W'(1);

  always_comb begin
    unique case (mode_w)
      DIV_LIN:  next_term_w = lin_term_w;
      default:  next_term_w = pow_term_w;
    endcase
  end

  // terminal count = half-period - 1, frozen while a burst runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     term_q <= '0;
    else if (load_i) term_q <= next_term_w;
  end

  assign term_o = term_q;

endmodule

// File: rtl/sclk_div_cnt.sv
module sclk_div_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             live_w;
  logic             at_term_w;

  assign live_w    = run_i & armed_i;
  assign at_term_w = (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!live_w)   cnt_q <= '0;
    else if (at_term_w) cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = live_w & at_term_w;

endmodule

// File: rtl/sclk_div_edge.sv
module sclk_div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);

  // phase 0 = idle level, 1 = active level
  logic phase_q;
  logic lead_q;
  logic trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= tick_i & ~phase_q;
      trail_q <= tick_i &  phase_q;
      if (tick_i) phase_q <= ~phase_q;
    end
  end

  assign sclk_o  = phase_q ^ cpol_i;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LIN_W-1:0] lin_div_i,
  input  logic [EXP_W-1:0] exp_div_i,
  input  logic             lin_mode_i,
  input  logic             run_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);

  localparam int unsigned CNT_W = cnt_width(LIN_W, EXP_W);

  logic             armed_q;
  logic [CNT_W-1:0] term_w;
  logic             tick_w;

  // armed one cycle after run_i is first sampled high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= run_i;
  end

  sclk_div_cfg #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (~armed_q),
    .lin_div_i  (lin_div_i),
    .exp_div_i  (exp_div_i),
    .lin_mode_i (lin_mode_i),
    .term_o     (term_w)
  );

  sclk_div_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .armed_i (armed_q),
    .term_i  (term_w),
    .tick_o  (tick_w)
  );

  sclk_div_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .tick_i  (tick_w),
    .cpol_i  (cpol_i),
    .sclk_o  (sclk_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );

endmodule

// File: rtl/spi_sclk_div_chk.sv
module spi_sclk_div_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cpol_i,
  input logic             sclk_o,
  input logic             lead_o,
  input logic             trail_o,
  input logic [CNT_W-1:0] term_w
);

  a_r4_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sclk_o == cpol_i));

  a_r8_no_strobe_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!lead_o && !trail_o));

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  a_r6_lead_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != cpol_i));

  a_r6_trail_at_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o == cpol_i));

  a_r6_lead_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);

  a_r6_trail_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |=> !trail_o);

  a_r5_edge_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && $stable(cpol_i) && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o));

  a_r7_frozen_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i) |-> $stable(term_w));

endmodule

bind spi_sclk_div spi_sclk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .cpol_i  (cpol_i),
  .sclk_o  (sclk_o),
  .lead_o  (lead_o),
  .trail_o (trail_o),
  .term_w  (term_w)
);

// File: tb/spi_sclk_div_bench.sv
`timescale 1ns/1ps
module spi_sclk_div_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lin_div_i = '0;
  logic [3:0] exp_div_i = '0;
  logic       lin_mode_i = 1'b1;
  logic       run_i = 1'b0;
  logic       cpol_i = 1'b0;
  logic       sclk_o, lead_o, trail_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spi_sclk_div u_spi_sclk_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lin_div_i  (lin_div_i),
    .exp_div_i  (exp_div_i),
    .lin_mode_i (lin_mode_i),
    .run_i      (run_i),
    .cpol_i     (cpol_i),
    .sclk_o     (sclk_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // negedges until the chosen strobe is seen
  task automatic wait_strobe(bit want_lead, int cap, output int n);
    n = 0;
    for (int k = 0; k < cap; k++) begin
      @(negedge clk_i);
      n++;
      if (lead_o && trail_o) chk(1'b0, "R6", "both strobes", 1, 0);
      if (want_lead ? lead_o : trail_o) break;
    end
  endtask

  task automatic stop_burst(string req);
    run_i = 1'b0;
    @(negedge clk_i);
    chk(sclk_o == cpol_i, req, "sclk after stop", sclk_o, cpol_i);
    chk(!lead_o && !trail_o, req, "strobes after stop", lead_o + trail_o, 0);
    @(negedge clk_i);
  endtask

  task automatic run_case(string req, bit mode, int nlin, int mexp, bit pol, int half, bit second);
    int n;
    lin_mode_i = mode; lin_div_i = 8'(nlin); exp_div_i = 4'(mexp); cpol_i = pol;
    repeat (2) @(negedge clk_i);
    chk(sclk_o == pol, "R4", "idle level", sclk_o, pol);
    run_i = 1'b1;
    wait_strobe(1'b1, half + 4, n);
    chk(n == half + 1, req, "first lead delay", n, half + 1);
    chk(sclk_o != pol, "R6", "level at lead", sclk_o, !pol);
    wait_strobe(1'b0, half + 4, n);
    chk(n == half, req, "lead to trail", n, half);
    chk(sclk_o == pol, "R6", "level at trail", sclk_o, pol);
    if (second) begin
      wait_strobe(1'b1, half + 4, n);
      chk(n == half, "R5", "trail to lead", n, half);
    end
    stop_burst("R8");
  endtask

  task automatic t_reset;
    chk(sclk_o == 1'b0 && !lead_o && !trail_o, "R4", "reset state",
        {sclk_o, lead_o, trail_o}, 0);
  endtask

  task automatic t_idle_cpol;
    cpol_i = 1'b1;
    @(negedge clk_i);
    chk(sclk_o == 1'b1, "R4", "idle follows cpol high", sclk_o, 1);
    cpol_i = 1'b0;
    @(negedge clk_i);
    chk(sclk_o == 1'b0, "R4", "idle follows cpol low", sclk_o, 0);
  endtask

  task automatic t_mid_burst;
    int n;
    lin_mode_i = 1'b1; lin_div_i = 8'd3; exp_div_i = 4'd6; cpol_i = 1'b0;
    repeat (2) @(negedge clk_i);
    run_i = 1'b1;
    wait_strobe(1'b1, 10, n);
    chk(n == 5, "R7", "lead before change", n, 5);
    lin_div_i = 8'd0; lin_mode_i = 1'b0; exp_div_i = 4'd0;
    wait_strobe(1'b0, 10, n);
    chk(n == 4, "R7", "trail after change", n, 4);
    wait_strobe(1'b1, 10, n);
    chk(n == 4, "R7", "lead after change", n, 4);
    stop_burst("R8");
    run_i = 1'b1;
    wait_strobe(1'b1, 10, n);
    chk(n == 2, "R8", "restart uses new divisor", n, 2);
    wait_strobe(1'b0, 10, n);
    chk(n == 1, "R8", "restart half", n, 1);
    stop_burst("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle_cpol();
    run_case("R1", 1'b1, 0,   0, 1'b0, 1,   1'b1);
    run_case("R1", 1'b1, 3,   9, 1'b0, 4,   1'b1);
    run_case("R1", 1'b1, 255, 0, 1'b1, 256, 1'b1);
    run_case("R2", 1'b0, 77,  0, 1'b0, 1,   1'b1);
    run_case("R2", 1'b0, 0,   3, 1'b1, 8,   1'b1);
    run_case("R3", 1'b1, 3,   5, 1'b0, 4,   1'b1);
    run_case("R3", 1'b0, 3,   5, 1'b0, 32,  1'b1);
    t_mid_burst();
    run_case("R2", 1'b0, 0,  15, 1'b0, 32768, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule